// File: doc/BRIEF.md
# Timing Reference Selection Controller

This block decides which timing reference a bus clock module's phase-locked loop should track. Software programs a role: primary master, secondary master or slave. Each role has its own main reference, its own backup reference and its own set of driven bus clocks. The block watches a validity flag for every reference. It brings those flags into its clock domain through two flops, and from them it picks the reference to follow.

When the followed reference goes bad, the block does not switch at once. It enters holdover, so the loop keeps its last frequency. It stays there for a programmable number of cycles and only then moves to the backup, and only if the backup is valid. If the lost reference comes back during holdover, the block returns to it with no switch. While it runs on the backup, a returning main reference is taken back at once unless a keep-backup bit says otherwise. Software promotes the block by writing a new role, and selection then restarts on the new role's main reference. Every state change sets a sticky interrupt flag, which software clears by writing one.

Top module: `ref_sel_ctrl`

## Requirements
- R1: After a synchronous active-low reset, with all validity flags high, the block follows the main reference of the programmed role, holdover_o is 0 and irq_o is 0.
- R2: The driven clock set follows the registered role, one cycle after role_i changes. Role 0 (primary master) sets drive_a_o only. Role 1 (secondary master) sets drive_b_o only. Roles 2 (slave) and 3 (treated as slave) set neither.
- R3: Reference codes are bit positions in ref_ok_i: 0 primary reference, 1 A bus clocks, 2 B bus clocks, 3 CT reference 1, 4 CT reference 2, 5+k local reference k. The main reference is code 0 for role 0 and code 1 for the other roles. The backup for roles 2 and 3 is code 2. For roles 0 and 1 the backup is taken from bsel_i: values 0..7 select code 5+bsel_i, 8 selects code 3, 9 selects code 4, and any other value selects code 15, which is never valid.
- R4: When the validity flag of the followed reference drops, holdover_o rises exactly three clock edges later (two synchronising flops plus the state register), and sel_src_o does not change.
- R5: With the backup valid, holdover after a loss of the main reference lasts exactly hold_len_i+1 cycles. Then sel_src_o shows the backup code and holdover_o falls.
- R6: If the failed reference becomes valid again before the holdover count expires, the block returns to it without selecting the other reference.
- R7: If the reference to switch to is never valid, the block stays in holdover indefinitely.
- R8: While on the backup with keep_backup_i=0, a main reference that turns valid again is selected directly, with no holdover.
- R9: While on the backup with keep_backup_i=1, the block stays on a valid backup even when the main reference is valid.
- R10: Loss of the backup while on it enters holdover. After hold_len_i+1 cycles the block goes back to the main reference if that reference is valid.
- R11: A change of role_i forces selection of the new role's main reference one cycle later, from any state.
- R12: irq_o is a sticky flag that is set on every state change. A one on irq_clr_i clears it, and a state change in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| role_i | input | 2 | Programmed role: 0 primary master, 1 secondary master, 2/3 slave |
| keep_backup_i | input | 1 | 1 keeps the backup after the main reference recovers |
| bsel_i | input | 4 | Backup choice for roles 0 and 1 |
| hold_len_i | input | 16 | Holdover length before a switch, in cycles minus one |
| ref_ok_i | input | 13 | Raw validity flag per reference code |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt flag |
| sel_src_o | output | 4 | Code of the reference followed or held |
| holdover_o | output | 1 | Loop is in holdover |
| drive_a_o | output | 1 | Block drives the A bus clocks |
| drive_b_o | output | 1 | Block drives the B bus clocks |
| irq_o | output | 1 | Interrupt, sticky until cleared |

## Verification
The hardest situations to reach are the holdover-from-backup path and the cases where two events land in the same cycle, such as a flag recovering just as the holdover count expires or a role change during holdover. Directed sequences first place the block on its backup with keep-backup set and then drop the backup. They line up an interrupt clear with a state change, and they promote a slave while it is on its B-clock backup. A seeded random phase then toggles validity flags, backup choice, holdover length, keep bit and role at low rates. A bench model steps through the requirements cycle by cycle and is compared with the outputs on every cycle.

// File: rtl/ref_sel_pkg.sv
// Shared codes for the timing reference selection controller.
// Assumes reference codes equal bit positions in the validity vector.
package ref_sel_pkg;
    localparam logic [1:0] ROLE_PRI = 2'd0;
    localparam logic [1:0] ROLE_SEC = 2'd1;
    localparam logic [1:0] ROLE_SLV = 2'd2;

    localparam int SRC_PRI  = 0;
    localparam int SRC_A    = 1;
    localparam int SRC_B    = 2;
    localparam int SRC_CT1  = 3;
    localparam int SRC_CT2  = 4;
    localparam int SRC_LOC0 = 5;

    typedef enum logic [1:0] {
        ST_MAIN      = 2'd0,
        ST_HOLD_MAIN = 2'd1,
        ST_BACK      = 2'd2,
        ST_HOLD_BACK = 2'd3
    } sel_st_e;
endpackage

// File: rtl/ref_ok_sync.sv
// Two-flop synchroniser for the raw reference validity flags.
// Assumes each flag is a slow level. The flops reset high, so every reference
// counts as valid until a low flag has passed through both stages.
module ref_ok_sync #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] ok_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the raw flags through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '1;
            stage2_q <= '1;
        end else begin
            stage1_q <= raw_i;
            stage2_q <= stage1_q;
        end
    end

    assign ok_o = stage2_q;

    // R4: the synchronised flags lag the raw flags by two edges
    a_r4_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n, 1)) |-> (ok_o == $past(raw_i, 2)));
endmodule

// File: rtl/ref_role_map.sv
// Registers the role and maps it to the main and backup reference codes and
// the driven clock set. Assumes bsel_i may change at any time; the backup
// code follows it directly.
module ref_role_map
    import ref_sel_pkg::*;
#(
    parameter int NUM_LOCAL = 8,
    parameter int SRC_W     = 4,
    parameter int BSEL_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        role_i,
    input  logic [BSEL_W-1:0] bsel_i,
    output logic              role_chg_o,
    output logic [SRC_W-1:0]  main_src_o,
    output logic [SRC_W-1:0]  back_src_o,
    output logic              drive_a_o,
    output logic              drive_b_o
);
    logic [1:0] role_q;
    logic       is_slave;

    // Hold the role that the selection logic currently works under.
    always_ff @(posedge clk) begin
        if (!rst_n) role_q <= role_i;
        else        role_q <= role_i;
    end

    assign role_chg_o = (role_i != role_q);
    assign is_slave   = (role_q != ROLE_PRI) && (role_q != ROLE_SEC);

    // The main reference is the primary input for a primary master, else the A clocks.
    assign main_src_o = (role_q == ROLE_PRI) ? SRC_W'(SRC_PRI) : SRC_W'(SRC_A);

    // Backup: B clocks for a slave, else the programmed local or CT reference.
    always_comb begin
        if (is_slave)
            back_src_o = SRC_W'(SRC_B);
        else if (int'(bsel_i) < NUM_LOCAL)
            back_src_o = SRC_W'(SRC_LOC0 + int'(bsel_i));
        else if (int'(bsel_i) == NUM_LOCAL)
            back_src_o = SRC_W'(SRC_CT1);
        else if (int'(bsel_i) == NUM_LOCAL + 1)
            back_src_o = SRC_W'(SRC_CT2);
        else
            back_src_o = '1;
    end

    assign drive_a_o = (role_q == ROLE_PRI);
    assign drive_b_o = (role_q == ROLE_SEC);

    // R2: at most one clock set is driven
    a_r2_drive_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drive_a_o, drive_b_o}));
    // R2: the A set follows the role written one cycle earlier
    a_r2_drive_follow: assert property (@(posedge clk) disable iff (!rst_n)
        role_chg_o |=> (drive_a_o == ($past(role_i) == ROLE_PRI)));
endmodule

// File: rtl/ref_sel_fsm.sv
// Selection state machine: follows the main or backup reference, and inserts a
// counted holdover before any switch that follows a loss. Assumes the flags are
// already synchronised. Code values of NREF or above are never valid.
module ref_sel_fsm
    import ref_sel_pkg::*;
#(
    parameter int NREF  = 13,
    parameter int SRC_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREF-1:0]  ok_i,
    input  logic [SRC_W-1:0] main_src_i,
    input  logic [SRC_W-1:0] back_src_i,
    input  logic             keep_i,
    input  logic [CNT_W-1:0] hold_len_i,
    input  logic             role_chg_i,
    output logic [SRC_W-1:0] sel_src_o,
    output logic             holdover_o,
    output logic             chg_o
);
    localparam int PAD_W = (1 << SRC_W);

    sel_st_e           state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
    logic [PAD_W-1:0]  ok_pad;
    logic              main_ok, back_ok, hold_done;

    assign ok_pad    = {{(PAD_W-NREF){1'b0}}, ok_i};
    assign main_ok   = ok_pad[main_src_i];
    assign back_ok   = ok_pad[back_src_i];
    assign hold_done = (cnt_q >= hold_len_i);
    assign cnt_inc   = (&cnt_q) ? cnt_q : cnt_q + 1'b1;

    // Next state and holdover count; the count restarts on every state entry.
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        if (role_chg_i) begin
            state_d = ST_MAIN;
        end else begin
            case (state_q)
                ST_MAIN: begin
                    if (!main_ok) state_d = ST_HOLD_MAIN;
                end
                ST_HOLD_MAIN: begin
                    if (main_ok)                    state_d = ST_MAIN;
                    else if (hold_done && back_ok)  state_d = ST_BACK;
                    else                            cnt_d   = cnt_inc;
                end
                ST_BACK: begin
                    if (main_ok && !keep_i)         state_d = ST_MAIN;
                    else if (!back_ok)              state_d = ST_HOLD_BACK;
                end
                default: begin
                    if (back_ok)                    state_d = ST_BACK;
                    else if (hold_done && main_ok)  state_d = ST_MAIN;
                    else                            cnt_d   = cnt_inc;
                end
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_MAIN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign sel_src_o  = (state_q == ST_MAIN || state_q == ST_HOLD_MAIN) ? main_src_i : back_src_i;
    assign holdover_o = (state_q == ST_HOLD_MAIN || state_q == ST_HOLD_BACK);
    assign chg_o      = (state_d != state_q);

    // R4: losing the followed main reference leads into holdover
    a_r4_hold_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MAIN && !main_ok && !role_chg_i) |=> holdover_o);
    // R5: no switch to the backup before the count has run out
    a_r5_no_early_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD_MAIN && cnt_q < hold_len_i && !role_chg_i) |=> (state_q != ST_BACK));
    // R7: with nothing valid, holdover persists
    a_r7_hold_forever: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD_MAIN && !main_ok && !back_ok && !role_chg_i) |=> (state_q == ST_HOLD_MAIN));
    // R9: the keep bit holds a valid backup
    a_r9_keep_backup: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BACK && keep_i && back_ok && !role_chg_i) |=> (state_q == ST_BACK));
    // R11: a role change restarts on the main reference
    a_r11_role_restart: assert property (@(posedge clk) disable iff (!rst_n)
        role_chg_i |=> (state_q == ST_MAIN));
endmodule

// File: rtl/ref_irq_flag.sv
// Sticky interrupt flag: set by a state-change pulse, cleared by write-one.
// Assumes the set pulse takes priority over a clear in the same cycle.
module ref_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    logic irq_q;

    // Update the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_q <= 1'b0;
        else if (set_i) irq_q <= 1'b1;
        else if (clr_i) irq_q <= 1'b0;
    end

    assign irq_o = irq_q;

    // R12: a state change always leaves the flag set
    a_r12_set_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> irq_o);
    // R12: a clear with no state change drops the flag
    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !irq_o);
endmodule

// File: rtl/ref_sel_ctrl.sv
// Top of the timing reference selection controller. It connects the
// synchroniser, role map, selection state machine and interrupt flag.
// Assumes all inputs except ref_ok_i are synchronous to clk.
module ref_sel_ctrl #(
    parameter int NUM_LOCAL = 8,
    parameter int CNT_W     = 16,
    localparam int NREF     = 5 + NUM_LOCAL,
    localparam int SRC_W    = $clog2(NREF + 1),
    localparam int BSEL_W   = $clog2(NUM_LOCAL + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        role_i,
    input  logic              keep_backup_i,
    input  logic [BSEL_W-1:0] bsel_i,
    input  logic [CNT_W-1:0]  hold_len_i,
    input  logic [NREF-1:0]   ref_ok_i,
    input  logic              irq_clr_i,
    output logic [SRC_W-1:0]  sel_src_o,
    output logic              holdover_o,
    output logic              drive_a_o,
    output logic              drive_b_o,
    output logic              irq_o
);
    logic [NREF-1:0]  ok_s;
    logic             role_chg;
    logic [SRC_W-1:0] main_src, back_src;
    logic             st_chg;

    ref_ok_sync #(.W(NREF)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (ref_ok_i),
        .ok_o  (ok_s)
    );

    ref_role_map #(.NUM_LOCAL(NUM_LOCAL), .SRC_W(SRC_W), .BSEL_W(BSEL_W)) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .role_i     (role_i),
        .bsel_i     (bsel_i),
        .role_chg_o (role_chg),
        .main_src_o (main_src),
        .back_src_o (back_src),
        .drive_a_o  (drive_a_o),
        .drive_b_o  (drive_b_o)
    );

    ref_sel_fsm #(.NREF(NREF), .SRC_W(SRC_W), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ok_i       (ok_s),
        .main_src_i (main_src),
        .back_src_i (back_src),
        .keep_i     (keep_backup_i),
        .hold_len_i (hold_len_i),
        .role_chg_i (role_chg),
        .sel_src_o  (sel_src_o),
        .holdover_o (holdover_o),
        .chg_o      (st_chg)
    );

    ref_irq_flag u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (st_chg),
        .clr_i (irq_clr_i),
        .irq_o (irq_o)
    );
endmodule

// File: tb/tb_ref_sel_ctrl.sv
`timescale 1ns/1ps
module tb_ref_sel_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  role = 2'd0;
    logic        keep = 1'b0;
    logic [3:0]  bsel = 4'd2;
    logic [15:0] hold_len = 16'd4;
    logic [12:0] ref_ok = '1;
    logic        irq_clr = 1'b0;
    logic [3:0]  sel;
    logic        hold, drv_a, drv_b, irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    ref_sel_ctrl dut (
        .clk(clk), .rst_n(rst_n), .role_i(role), .keep_backup_i(keep),
        .bsel_i(bsel), .hold_len_i(hold_len), .ref_ok_i(ref_ok),
        .irq_clr_i(irq_clr), .sel_src_o(sel), .holdover_o(hold),
        .drive_a_o(drv_a), .drive_b_o(drv_b), .irq_o(irq)
    );

    // Requirement-level model: codes from R3, timing from R4/R5, irq from R12.
    function automatic int main_of(int r);
        return (r == 0) ? 0 : 1;
    endfunction
    function automatic int back_of(int r, int b);
        if (r >= 2) return 2;
        if (b < 8)  return 5 + b;
        if (b == 8) return 3;
        if (b == 9) return 4;
        return 15;
    endfunction
    function automatic bit okv(logic [12:0] v, int c);
        return (c < 13) ? v[c] : 1'b0;
    endfunction

    logic [12:0] m_s1, m_s2;
    int m_role, m_st, m_cnt;
    bit m_irq;

    always @(posedge clk) begin
        int mc, bc, ns, nc;
        bit mo, bo, hd;
        if (!rst_n) begin
            m_s1 <= '1; m_s2 <= '1; m_role <= int'(role);
            m_st <= 0; m_cnt <= 0; m_irq <= 1'b0;
        end else begin
            mc = main_of(m_role); bc = back_of(m_role, int'(bsel));
            mo = okv(m_s2, mc);   bo = okv(m_s2, bc);
            hd = (m_cnt >= int'(hold_len));
            ns = m_st; nc = 0;
            if (int'(role) != m_role) ns = 0;
            else case (m_st)
                0: if (!mo) ns = 1;
                1: if (mo) ns = 0; else if (hd && bo) ns = 2; else nc = m_cnt + 1;
                2: if (mo && !keep) ns = 0; else if (!bo) ns = 3;
                default: if (bo) ns = 2; else if (hd && mo) ns = 0; else nc = m_cnt + 1;
            endcase
            if (ns != m_st) m_irq <= 1'b1; else if (irq_clr) m_irq <= 1'b0;
            m_st <= ns; m_cnt <= nc;
            m_s2 <= m_s1; m_s1 <= ref_ok; m_role <= int'(role);
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance one cycle and compare every output against the model.
    task automatic tick();
        int e_sel, exp_v, act_v;
        @(negedge clk);
        if (rst_n) begin
            e_sel = (m_st < 2) ? main_of(m_role) : back_of(m_role, int'(bsel));
            exp_v = (e_sel << 4) | (int'(m_st == 1 || m_st == 3) << 3) |
                    (int'(m_role == 0) << 2) | (int'(m_role == 1) << 1) | int'(m_irq);
            act_v = (int'(sel) << 4) | (int'(hold) << 3) | (int'(drv_a) << 2) |
                    (int'(drv_b) << 1) | int'(irq);
            chk(cur_req, act_v, exp_v);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));
        ticks(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1", int'(sel), 0); chk("R1", int'(hold), 0); chk("R1", int'(irq), 0);
        chk("R2", int'(drv_a), 1);

        // R4 loss timing
        cur_req = "R4";
        ref_ok[0] = 1'b0;
        ticks(2); chk("R4", int'(hold), 0);
        tick();   chk("R4", int'(hold), 1); chk("R4", int'(sel), 0);
        chk("R12", int'(irq), 1);

        // R5 holdover length, backup local 2 is code 7
        cur_req = "R5";
        n = 1;
        for (int i = 0; i < 100; i++) begin tick(); if (hold) n++; else break; end
        chk("R5", n, 5); chk("R5", int'(sel), 7);

        // R12 clear with no state change
        cur_req = "R12";
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;
        chk("R12", int'(irq), 0);

        // R8 direct revert
        cur_req = "R8";
        ref_ok[0] = 1'b1;
        ticks(2); chk("R8", int'(sel), 7);
        tick();   chk("R8", int'(sel), 0); chk("R8", int'(hold), 0);

        // R9 keep backup
        cur_req = "R9";
        keep = 1'b1; ref_ok[0] = 1'b0; ticks(8);
        chk("R9", int'(sel), 7);
        ref_ok[0] = 1'b1; ticks(10);
        chk("R9", int'(sel), 7); chk("R9", int'(hold), 0);

        // R10 loss of the backup, then return to main
        cur_req = "R10";
        ref_ok[7] = 1'b0; ticks(3);
        chk("R10", int'(hold), 1); chk("R10", int'(sel), 7);
        ticks(5);
        chk("R10", int'(hold), 0); chk("R10", int'(sel), 0);
        ref_ok[7] = 1'b1; keep = 1'b0; ticks(3);

        // R6 recovery inside the holdover window
        cur_req = "R6";
        hold_len = 16'd20; ref_ok[0] = 1'b0; ticks(3);
        chk("R6", int'(hold), 1);
        ref_ok[0] = 1'b1; ticks(3);
        chk("R6", int'(hold), 0); chk("R6", int'(sel), 0);

        // R7 backup code never valid
        cur_req = "R7";
        bsel = 4'd12; hold_len = 16'd2; ref_ok[0] = 1'b0; ticks(50);
        chk("R7", int'(hold), 1); chk("R7", int'(sel), 0);
        ref_ok[0] = 1'b1; ticks(3);

        // R12 set wins over a coincident clear
        cur_req = "R12";
        ref_ok[0] = 1'b0; ticks(2);
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;
        chk("R12", int'(irq), 1); chk("R12", int'(hold), 1);
        ref_ok[0] = 1'b1; bsel = 4'd2; ticks(4);

        // R2/R3 secondary master with CT reference 1 as backup
        cur_req = "R3";
        role = 2'd1; tick();
        chk("R2", int'(drv_b), 1); chk("R2", int'(drv_a), 0); chk("R3", int'(sel), 1);
        bsel = 4'd8; hold_len = 16'd1; ref_ok[1] = 1'b0; ticks(5);
        chk("R3", int'(sel), 3); chk("R3", int'(hold), 0);
        ref_ok[1] = 1'b1; ticks(3);

        // R3 slave falls back to B clocks, R11 promotion to secondary
        role = 2'd2; tick();
        chk("R2", int'(drv_a) + int'(drv_b), 0);
        ref_ok[1] = 1'b0; ticks(5);
        chk("R3", int'(sel), 2);
        cur_req = "R11";
        role = 2'd1; tick();
        chk("R11", int'(sel), 1); chk("R11", int'(hold), 0); chk("R11", int'(drv_b), 1);
        ref_ok[1] = 1'b1; ticks(4);

        // Seeded random mix of flags, choices and roles
        cur_req = "R3";
        for (int c = 0; c < 4000; c++) begin
            int r;
            r = $urandom % 100;
            if (r < 6) begin
                case ($urandom % 4)
                    0: ref_ok[0] = ~ref_ok[0];
                    1: ref_ok[1] = ~ref_ok[1];
                    2: ref_ok[2] = ~ref_ok[2];
                    default: ref_ok[$urandom % 13] = ~ref_ok[$urandom % 13];
                endcase
            end else if (r < 8)  keep = ~keep;
            else if (r == 8)     bsel = 4'($urandom % 11);
            else if (r == 9)     role = 2'($urandom % 4);
            else if (r == 10)    hold_len = 16'($urandom % 7);
            irq_clr = (($urandom % 8) == 0);
            tick();
        end
        irq_clr = 1'b0;
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule